// File: doc/BRIEF.md
# Access Control Region Matcher

This block holds a small bank of programmable region descriptors and compares every memory access against all of them at once. Each descriptor names an address window through an 8-bit base and an 8-bit don't-care mask, restricts itself to user accesses, supervisor accesses or both, and carries a cache mode plus two protection bits. When an access falls inside an enabled window, the block reports a hit, supplies that window's cache mode in place of the paged attributes, and raises a protection-violation flag if the access breaks the window's write or supervisor restriction.

Descriptors are loaded through a simple write port: a select and a 32-bit word. A descriptor word of zero turns the window off. The access side takes an address, a supervisor flag and a write flag every cycle. All three results are registered and appear one clock after the access is presented.

Top module: `acr_matcher`

## Requirements
- R1: After synchronous reset every descriptor is cleared to zero, so every window is disabled and `hit`, `cache_mode` and `prot_viol` read 0.
- R2: A cycle with `cfg_we` high stores `cfg_wdata` into the descriptor picked by `cfg_sel`; accesses presented in later cycles see the new value. Writing zero disables that descriptor.
- R3: A descriptor is enabled by bit 15. With bit 10 clear (coarse regions), it matches when address bits 31:24 equal the base in descriptor bits 31:24 on every bit where the mask in descriptor bits 23:16 holds 0; a mask bit of 1 makes that address bit don't-care.
- R4: With bit 10 set (fine regions), the base and mask are instead compared against address bits 23:16, and the match further requires address bits 31:24 to be zero.
- R5: Descriptor bits 14:13 qualify the match by privilege: 0 matches user accesses only, 1 supervisor accesses only, 2 and 3 both.
- R6: On a hit `cache_mode` carries descriptor bits 6:5 (0 write-through, 1 copy-back, 2 inhibited precise, 3 inhibited imprecise); with no hit it reads 0.
- R7: When several descriptors match, the one with the lowest index supplies cache mode and protection.
- R8: `prot_viol` is 1 on a hit when the access is a write and the winning descriptor has write-protect (bit 2) set, or when the access is a user access and the winning descriptor has supervisor-protect (bit 3) set; it is 0 otherwise and never set without a hit.
- R9: Results are registered: `hit`, `cache_mode` and `prot_viol` reflect the access inputs sampled at the previous rising clock edge.
- R10: A coarse descriptor with base 0x80 and mask 0x7F matches every address from 0x80000000 to 0xFFFFFFFF and no address below 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 2 | Index of the descriptor to write |
| cfg_wdata | input | 32 | Descriptor word to store |
| acc_addr | input | 32 | Access address |
| acc_super | input | 1 | 1 for a supervisor access, 0 for user |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| hit | output | 1 | Access matched an enabled descriptor |
| cache_mode | output | 2 | Cache mode of the winning descriptor |
| prot_viol | output | 1 | Access violates the winning descriptor's protection |

## Verification
Every result is due exactly one rising edge after the access is driven, and a descriptor write is visible to the access presented in the cycle after the write edge. The bench therefore drives inputs on the falling edge and compares outputs on the following falling edge, against a model that applies the requirement rules to its own copy of the descriptor words. One check samples just before the edge to show the outputs still hold the earlier access, confirming the single register stage.

// File: rtl/acr_pkg.sv
package acr_pkg;

    // Bit positions within a descriptor word; the write port decodes these.
    localparam int BASE_MSB  = 31;
    localparam int BASE_LSB  = 24;
    localparam int MASK_MSB  = 23;
    localparam int MASK_LSB  = 16;
    localparam int EN_BIT    = 15;
    localparam int MODE_MSB  = 14;
    localparam int MODE_LSB  = 13;
    localparam int FINE_BIT  = 10;
    localparam int CM_MSB    = 6;
    localparam int CM_LSB    = 5;
    localparam int SP_BIT    = 3;
    localparam int WP_BIT    = 2;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_BOTH  = 2'd2,
        PRIV_ANY   = 2'd3
    } priv_sel_e;

    typedef enum logic [1:0] {
        CM_WRTHRU   = 2'd0,
        CM_COPYBACK = 2'd1,
        CM_INH_PREC = 2'd2,
        CM_INH_IMPR = 2'd3
    } cmode_e;

    typedef struct packed {
        logic [7:0] base;
        logic [7:0] mask;
        logic       en;
        priv_sel_e  priv;
        logic       fine;
        cmode_e     cmode;
        logic       sup_prot;
        logic       wr_prot;
    } region_t;

    function automatic region_t decode_word(input logic [31:0] w);
        region_t r;
        r.base     = w[BASE_MSB:BASE_LSB];
        r.mask     = w[MASK_MSB:MASK_LSB];
        r.en       = w[EN_BIT];
        r.priv     = priv_sel_e'(w[MODE_MSB:MODE_LSB]);
        r.fine     = w[FINE_BIT];
        r.cmode    = cmode_e'(w[CM_MSB:CM_LSB]);
        r.sup_prot = w[SP_BIT];
        r.wr_prot  = w[WP_BIT];
        return r;
    endfunction

    function automatic logic priv_ok(input priv_sel_e p, input logic is_super);
        case (p)
            PRIV_USER:  return !is_super;
            PRIV_SUPER: return is_super;
            default:    return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/acr_regfile.sv
module acr_regfile
    import acr_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int SEL_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [SEL_W-1:0]    sel,
    input  logic [31:0]         wdata,
    output region_t [NREG-1:0]  regions
);

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                regions[i] <= '0;
            end else if (we && sel == SEL_W'(i)) begin
                regions[i] <= decode_word(wdata);
            end
        end

        AST_ZERO_WRITE_DISABLES: assert property (@(posedge clk) disable iff (rst)
            (we && sel == SEL_W'(i) && wdata == 32'd0) |=> !regions[i].en); // R2
    end

endmodule

// File: rtl/acr_match.sv
module acr_match
    import acr_pkg::*;
(
    input  region_t     region,
    input  logic [15:0] addr_hi,
    input  logic        is_super,
    input  logic        is_write,
    output logic        match,
    output logic        viol
);

    logic [7:0] cmp_byte;
    logic       upper_clear;
    logic       window_ok;

    always_comb begin
        cmp_byte    = region.fine ? addr_hi[7:0] : addr_hi[15:8];
        upper_clear = !region.fine || (addr_hi[15:8] == 8'h00);
        window_ok   = ((cmp_byte ^ region.base) & ~region.mask) == 8'h00;
        match       = region.en && upper_clear && window_ok && priv_ok(region.priv, is_super);
        viol        = (region.wr_prot && is_write) || (region.sup_prot && !is_super);
    end

endmodule

// File: rtl/acr_prio.sv
module acr_prio #(
    parameter int NREG = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREG-1:0] req,
    output logic [NREG-1:0] grant,
    output logic            any
);

    always_comb begin
        grant = '0;
        for (int i = 0; i < NREG; i++) begin
            if (req[i] && grant == '0) grant[i] = 1'b1;
        end
        any = |req;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R7
    AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        ((grant & ~req) == '0) && (any == (grant != '0))); // R7

endmodule

// File: rtl/acr_matcher.sv
module acr_matcher
    import acr_pkg::*;
#(
    parameter int NREG = 4,
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic [31:0]      acc_addr,
    input  logic             acc_super,
    input  logic             acc_write,
    output logic             hit,
    output logic [1:0]       cache_mode,
    output logic             prot_viol
);

    region_t [NREG-1:0] regions;
    logic [NREG-1:0]    match_vec;
    logic [NREG-1:0]    viol_vec;
    logic [NREG-1:0]    grant;
    logic               any_hit;
    logic [1:0]         cm_d;
    logic               viol_d;
    logic               unused_addr_lo;

    assign unused_addr_lo = ^acc_addr[15:0];

    acr_regfile #(.NREG(NREG), .SEL_W(SEL_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .regions (regions)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        acr_match u_match (
            .region   (regions[i]),
            .addr_hi  (acc_addr[31:16]),
            .is_super (acc_super),
            .is_write (acc_write),
            .match    (match_vec[i]),
            .viol     (viol_vec[i])
        );
    end

    acr_prio #(.NREG(NREG)) u_prio (
        .clk   (clk),
        .rst   (rst),
        .req   (match_vec),
        .grant (grant),
        .any   (any_hit)
    );

    always_comb begin
        cm_d   = 2'b00;
        viol_d = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            cm_d   = cm_d | ({2{grant[i]}} & regions[i].cmode);
            viol_d = viol_d | (grant[i] & viol_vec[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit        <= 1'b0;
            cache_mode <= 2'b00;
            prot_viol  <= 1'b0;
        end else begin
            hit        <= any_hit;
            cache_mode <= cm_d;
            prot_viol  <= viol_d;
        end
    end

    AST_RESET_CLEARS_OUT: assert property (@(posedge clk)
        rst |=> (!hit && cache_mode == 2'b00 && !prot_viol)); // R1
    AST_VIOL_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        prot_viol |-> hit); // R8
    AST_NOHIT_CMODE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit |-> cache_mode == 2'b00); // R6
    AST_HIT_FOLLOWS_MATCH: assert property (@(posedge clk) disable iff (rst)
        (match_vec != '0) |=> hit); // R9

endmodule

// File: tb/acr_matcher_tb.sv
module acr_matcher_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] acc_addr = '0;
    logic        acc_super = 1'b0;
    logic        acc_write = 1'b0;
    logic        hit;
    logic [1:0]  cache_mode;
    logic        prot_viol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] mreg [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    acr_matcher u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_addr(acc_addr), .acc_super(acc_super), .acc_write(acc_write),
        .hit(hit), .cache_mode(cache_mode), .prot_viol(prot_viol)
    );

    // Expected {hit, cache_mode, violation} from the requirement rules.
    function automatic logic [3:0] model(input logic [31:0] a, input logic s, input logic w);
        for (int i = 0; i < 4; i++) begin
            logic [31:0] d;
            logic [7:0]  f;
            d = mreg[i];
            if (!d[15]) continue;
            if (d[10] && a[31:24] != 8'h00) continue;
            f = d[10] ? a[23:16] : a[31:24];
            if (((f ^ d[31:24]) & ~d[23:16]) != 8'h00) continue;
            if (d[14:13] == 2'd0 && s) continue;
            if (d[14:13] == 2'd1 && !s) continue;
            return {1'b1, d[6:5], (d[2] & w) | (d[3] & !s)};
        end
        return 4'b0000;
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        checks++;
        if ({hit, cache_mode, prot_viol} !== exp) begin
            errors++;
            $display("FAIL %s addr=%h sup=%0b wr=%0b: got hit=%0b cm=%0d viol=%0b, expected hit=%0b cm=%0d viol=%0b",
                     tag, acc_addr, acc_super, acc_write, hit, cache_mode, prot_viol,
                     exp[3], exp[2:1], exp[0]);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic access(input string tag, input logic [31:0] a, input logic s, input logic w);
        logic [3:0] exp;
        acc_addr = a; acc_super = s; acc_write = w;
        exp = model(a, s, w);
        @(negedge clk);
        check(tag, exp);
    endtask

    task automatic write_reg(input logic [1:0] idx, input logic [31:0] val);
        cfg_we = 1'b1; cfg_sel = idx; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        mreg[idx] = val;
    endtask

    task automatic sweep(input string tag);
        logic [7:0] mids [4] = '{8'h00, 8'h12, 8'h13, 8'h1F};
        for (int hi = 0; hi < 256; hi++)
            for (int m = 0; m < 4; m++)
                for (int sw = 0; sw < 4; sw++)
                    access(tag, {hi[7:0], mids[m], 16'h5A5A}, sw[1], sw[0]);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired after %0d cycles", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mreg[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs clear, and all regions disabled after reset
        check("R1 reset outputs", 4'b0000);
        access("R1 disabled after reset", 32'hFFFF_0000, 1'b1, 1'b1);
        access("R1 disabled after reset", 32'h0000_0000, 1'b0, 1'b0);

        // R10: base 0x80, mask 0x7F, both modes, inhibited precise
        write_reg(2'd0, 32'h807F_C040);
        access("R10 low end", 32'h8000_0000, 1'b0, 1'b0);
        access("R10 high end", 32'hFFFF_FFFF, 1'b1, 1'b1);
        access("R10 below", 32'h7FFF_FFFF, 1'b1, 1'b0);
        for (int hi = 0; hi < 256; hi++)
            for (int sw = 0; sw < 4; sw++)
                access("R10/R3 sweep", {hi[7:0], 24'h00_1234}, sw[1], sw[0]);

        // R9: result appears only after the next rising edge
        acc_addr = 32'h1000_0000; acc_super = 1'b0; acc_write = 1'b0;
        @(negedge clk);
        check("R9 settle no-hit", 4'b0000);
        acc_addr = 32'h9000_0000;
        #1;
        check("R9 before edge", 4'b0000);
        @(negedge clk);
        check("R9 after edge", 4'b1100);

        // Overlapping mixed set: R3 R4 R5 R6 R7 R8
        write_reg(2'd0, 32'h100F_8024); // coarse 0x10/0x0F, user only, copy-back, write-prot
        write_reg(2'd1, 32'h001F_A068); // coarse 0x00/0x1F, super only, inh imprecise, sup-prot
        write_reg(2'd2, 32'hF000_C00C); // coarse 0xF0, both, write-thru, both prots
        write_reg(2'd3, 32'h1201_E440); // fine 0x12/0x01, any, inh precise
        access("R7 overlap user", 32'h1A00_0000, 1'b0, 1'b1);
        access("R7 overlap super", 32'h1A00_0000, 1'b1, 1'b0);
        access("R4 fine hit", 32'h0013_0000, 1'b0, 1'b0);
        access("R4 fine upper nonzero", 32'h2012_0000, 1'b1, 1'b0);
        access("R8 sup-prot user", 32'hF000_0000, 1'b0, 1'b0);
        access("R8 write-prot super", 32'hF000_0000, 1'b1, 1'b1);
        sweep("R3/R4/R5/R6/R7/R8 sweep");

        // R2: zero write disables descriptor 1, others unchanged
        write_reg(2'd1, 32'h0000_0000);
        access("R2 zero disables", 32'h0500_0000, 1'b1, 1'b0);
        sweep("R2/R7 sweep after disable");

        // R2: overwrite descriptor 0 with a supervisor-only window
        write_reg(2'd0, 32'h00FF_A020);
        access("R2 rewrite takes effect", 32'h4400_0000, 1'b1, 1'b0);
        access("R2 rewrite user miss", 32'h4400_0000, 1'b0, 1'b0);
        sweep("R2/R5/R6 sweep after rewrite");

        // R1: reset again clears descriptors
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) mreg[i] = 32'd0;
        check("R1 outputs after reset", 4'b0000);
        access("R1 regions cleared", 32'hF000_0000, 1'b1, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule